// File: doc/BRIEF.md
# Temperature-Aware Refresh Request Timer

This block paces auto-refresh requests for a DRAM subsystem built from two independently selected ranks. A single phase counter measures the average refresh interval, which is 64 ms divided into 8192 slots (7.8125 µs) while the memory is at or below 85 °C. A case-hot input halves that interval to about 3.9 µs, so the 8192 refreshes fit into 32 ms. The interval length in clock cycles is derived at elaboration from a clock-period parameter given in picoseconds.

Rank 0 is served when the counter wraps and rank 1 at the midpoint of the interval, so the two ranks never receive a new request in the same cycle. Each rank keeps a saturating count of refreshes that are owed, and its request stays high until the command scheduler has acknowledged every one of them. If the hot flag rises late in a normal interval, the counter is cut short at once, so no request waits longer than the hot interval. A separate output tells the rest of the memory system that the high-temperature self-refresh setting is required.

Top module: `refresh_req_timer`

## Requirements
- R1: While `rst_n` is sampled low, both pending counts, both requests and `srt_req_o` are 0 after the clock edge.
- R2: With `hot_i` low, rank 0 gains one pending refresh every NORM cycles, where NORM = floor(7,812,500 / CLK_PERIOD_PS). The first one is counted at the NORM-th rising edge after reset is released.
- R3: With `hot_i` high the interval is HOT = floor(NORM/2) cycles. If `hot_i` is sampled high while the phase counter is already at or past HOT-1, rank 0's request is counted at that same edge and the next interval starts.
- R4: Rank 1 gains its refresh when the phase counter reaches floor(L/2)-1 of the current interval length L. With defaults this is edge 976 after reset, and 488 edges after each wrap while hot. The two ranks never gain a refresh on the same edge: a rank 1 refresh that falls due on a wrap edge is counted one edge later.
- R5: Each new refresh adds one to that rank's pending count, and the count saturates at PEND_MAX (default 8).
- R6: An acknowledge on `ack_i[r]` subtracts one from rank r's pending count. An acknowledge while the count is 0 leaves it at 0.
- R7: A new refresh and an acknowledge for the same rank on the same edge leave its pending count unchanged.
- R8: `req_o[r]` is high exactly when rank r's pending count is nonzero.
- R9: `srt_req_o` equals the value `hot_i` had at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| hot_i | input | 1 | Case temperature above 85 °C |
| ack_i | input | 2 | Per-rank acknowledge that one refresh was issued; bit r is rank r |
| req_o | output | 2 | Per-rank refresh request; bit r is rank r |
| pend_o | output | 8 | Pending counts; bits [4r+3:4r] belong to rank r |
| srt_req_o | output | 1 | High-temperature self-refresh setting required |

## Verification
On every cycle the assertions check that the phase counter stays inside the interval and drops below the hot limit one edge after `hot_i` is sampled high. They also check that pending counts never exceed their cap, that acknowledges and new refreshes move the counts by exactly one, that the two ranks never gain a refresh together, and that `srt_req_o` follows `hot_i`. Only the bench scenarios can show that the absolute edge numbers of each refresh match the derived intervals. The same holds for the clamp at the moment the rate switches, saturation after a long run without acknowledges, and the coincident refresh-plus-acknowledge case.

// File: rtl/refresh_pkg.sv
// Shared constants for the refresh request timer.
// Assumes exactly two ranks, served half an interval apart.
package refresh_pkg;
    localparam int NUM_RANKS   = 2;
    // Length of one refresh slot when cool: 64 ms / 8192, in picoseconds.
    localparam int NORM_SLOT_PS = 7812500;
endpackage

// File: rtl/refresh_phase_gen.sv
// Phase counter for the refresh interval. Produces a one-cycle tick for rank 0
// at the wrap and for rank 1 at mid-interval. The interval halves while hot_i
// is high, and a long count is cut short at once.
// Assumes NORM_LIM >= 4.
module refresh_phase_gen #(
    parameter int NORM_LIM = 1953
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hot_i,
    output logic [1:0] tick_o
);
    localparam int HOT_LIM = NORM_LIM / 2;
    localparam int CW      = $clog2(NORM_LIM + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;   // rank 1 already served in this interval
    logic          owed_q;   // rank 1 was pushed aside by a wrap
    logic [CW-1:0] limit;
    logic          wrap;
    logic          due1;

    // Select the interval length and decode both tick conditions.
    always_comb begin
        limit = hot_i ? CW'(HOT_LIM) : CW'(NORM_LIM);
        wrap  = (cnt_q >= limit - CW'(1));
        due1  = (cnt_q >= (limit >> 1) - CW'(1)) && !done_q;
        tick_o[0] = wrap;
        tick_o[1] = owed_q || (due1 && !wrap);
    end

    // Advance the phase and track the rank 1 service state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            owed_q <= 1'b0;
        end else begin
            cnt_q  <= wrap ? '0 : cnt_q + CW'(1);
            owed_q <= wrap && due1;
            done_q <= wrap ? 1'b0 : (done_q || (due1 && !wrap));
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(NORM_LIM)); // R2
    AST_HOT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        hot_i |=> cnt_q < CW'(HOT_LIM)); // R3
endmodule

// File: rtl/refresh_pend_ctr.sv
// Saturating count of refreshes owed to one rank. It rises on a tick and falls
// on an acknowledge. Assumes the acknowledge is a one-cycle pulse per refresh.
module refresh_pend_ctr #(
    parameter int PEND_MAX = 8,
    parameter int PW       = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          ack_i,
    output logic [PW-1:0] cnt_o
);
    logic [PW-1:0] cnt_q;
    logic          take;

    // An acknowledge only counts when something is owed.
    assign take  = ack_i && (cnt_q != '0);
    assign cnt_o = cnt_q;

    // Update the owed count; a tick and a take together cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({tick_i, take})
                2'b10:   if (cnt_q < PW'(PEND_MAX)) cnt_q <= cnt_q + PW'(1);
                2'b01:   cnt_q <= cnt_q - PW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PW'(PEND_MAX)); // R5
    AST_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ack_i && cnt_q < PW'(PEND_MAX)) |=> cnt_q == $past(cnt_q) + PW'(1)); // R5
    AST_ACK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - PW'(1)); // R6
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && tick_i && cnt_q != '0) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/refresh_req_timer.sv
// Refresh request timer for two ranks. One phase generator serves both ranks
// half an interval apart, and each rank has its own pending counter.
// Assumes CLK_PERIOD_PS is at most a few thousand times below the 7.8 us slot.
module refresh_req_timer #(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int PEND_MAX      = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     hot_i,
    input  logic [refresh_pkg::NUM_RANKS-1:0]        ack_i,
    output logic [refresh_pkg::NUM_RANKS-1:0]        req_o,
    output logic [refresh_pkg::NUM_RANKS*4-1:0]      pend_o,
    output logic                                     srt_req_o
);
    import refresh_pkg::*;

    localparam int NORM_LIM = NORM_SLOT_PS / CLK_PERIOD_PS;
    localparam int PW       = $clog2(PEND_MAX + 1);

    logic [NUM_RANKS-1:0] tick;

    refresh_phase_gen #(.NORM_LIM(NORM_LIM)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .hot_i  (hot_i),
        .tick_o (tick)
    );

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic [PW-1:0] cnt;
        refresh_pend_ctr #(.PEND_MAX(PEND_MAX), .PW(PW)) u_pend (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick[r]),
            .ack_i  (ack_i[r]),
            .cnt_o  (cnt)
        );
        assign pend_o[4*r +: 4] = 4'(cnt);
        assign req_o[r]         = (cnt != '0);
    end

    // Flag the high-temperature self-refresh setting one edge after hot_i.
    always_ff @(posedge clk) begin
        if (!rst_n) srt_req_o <= 1'b0;
        else        srt_req_o <= hot_i;
    end

    AST_RANKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick[0] && tick[1])); // R4
    AST_SRT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        hot_i |=> srt_req_o); // R9
    AST_SRT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !hot_i |=> !srt_req_o); // R9
    AST_REQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o[0]) |-> $past(ack_i[0])); // R8
endmodule

// File: tb/refresh_req_timer_test.sv
`timescale 1ns/1ps
module refresh_req_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hot_i = 1'b0;
    logic [1:0] ack_i = 2'b00;
    logic [1:0] req_o;
    logic [7:0] pend_o;
    logic       srt_req_o;

    int checks = 0;
    int errors = 0;
    int total  = 0;   // rising edges since reset release

    refresh_req_timer uut (
        .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .ack_i(ack_i),
        .req_o(req_o), .pend_o(pend_o), .srt_req_o(srt_req_o)
    );

    always #2 clk = ~clk;

    // Vector table: edges to run, hot level, expected pending rank 0 / rank 1.
    localparam int NV = 11;
    localparam int V_RUN [0:NV-1] = '{975, 1, 976, 1, 976, 1, 487, 1, 487, 1, 5856};
    localparam int V_HOT [0:NV-1] = '{0,   0, 0,   0, 0,   1, 1,   1, 1,   1, 1};
    localparam int V_P0  [0:NV-1] = '{0,   0, 0,   1, 1,   2, 2,   2, 2,   3, 8};
    localparam int V_P1  [0:NV-1] = '{0,   1, 1,   1, 2,   2, 2,   3, 3,   3, 8};

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, total);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            total++;
        end
        @(negedge clk);
    endtask

    task automatic ack_once(input logic [1:0] m);
        ack_i = m;
        step(1);
        ack_i = 2'b00;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pend0 reset", pend_o[3:0], 0);
        check("R1 pend1 reset", pend_o[7:4], 0);
        check("R1 req reset", req_o, 0);
        check("R1 srt reset", srt_req_o, 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R8 R9: walk the table
        for (int v = 0; v < NV; v++) begin
            hot_i = V_HOT[v][0];
            step(V_RUN[v]);
            check("R2/R3 pend0", pend_o[3:0], V_P0[v]);
            check("R4 pend1", pend_o[7:4], V_P1[v]);
            check("R8 req0", req_o[0], (V_P0[v] != 0) ? 1 : 0);
            check("R8 req1", req_o[1], (V_P1[v] != 0) ? 1 : 0);
            check("R9 srt", srt_req_o, V_HOT[v]);
        end

        // Back to the normal rate at edge 9762 (counter just wrapped).
        hot_i = 1'b0;
        for (int i = 0; i < 8; i++) ack_once(2'b01);
        check("R6 drain pend0", pend_o[3:0], 0);
        check("R8 req0 low", req_o[0], 0);
        ack_once(2'b01);
        check("R6 ack at zero", pend_o[3:0], 0);
        for (int i = 0; i < 3; i++) ack_once(2'b10);
        check("R6 pend1 after acks", pend_o[7:4], 5);

        // R7: acknowledge on the very edge where rank 1 gains a refresh (10738).
        step(10737 - total);
        ack_once(2'b10);
        check("R7 tick with ack", pend_o[7:4], 5);
        check("R7 pend0 idle", pend_o[3:0], 0);

        // R2: next rank 0 refresh at edge 9762 + 1953 = 11715.
        step(11714 - total);
        check("R2 before wrap", pend_o[3:0], 0);
        step(1);
        check("R2 at wrap", pend_o[3:0], 1);

        // R1: reset in mid-run clears everything.
        hot_i = 1'b1;
        step(1);
        rst_n = 1'b0;
        step(1);
        check("R1 pend0 re-reset", pend_o[3:0], 0);
        check("R1 pend1 re-reset", pend_o[7:4], 0);
        check("R1 srt re-reset", srt_req_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule